// File: doc/BRIEF.md
# Monochrome 4-bit LCD Panel Timing Generator

This block drives the control and data pins of a single-colour passive LCD panel whose data bus is four bits wide. It turns a set of static configuration inputs into a line pulse, a frame pulse, a gated shift clock and an AC-drive toggle. It also streams pixel nibbles from an upstream source onto the panel data pins. All timing is counted in units of Ts, the panel pixel period. Ts is a selectable fraction of the memory clock.

The block runs on a clock at twice the memory-clock rate, so each Ts has a first half and a second half. The shift clock is high in the first half of a shifting Ts and low in the second half. A new nibble therefore appears at the rising side of the shift clock and is stable around the falling side, where the panel samples it. The upstream source offers a nibble with `px_valid`/`px_data`. The block takes it in the single cycle in which `px_ready` is high, which is the last cycle before a shift pulse starts. If no nibble is offered at that point, zeros are shifted out.

Each line has three parts: a fixed lead-in of 28 Ts (the 9-Ts line pulse plus a 19-Ts gap), then the display window, then the rest of the line period. Frames hold a programmable number of lines. When the block is enabled it first runs one lead-in line, which is the last line of a frame, so the first frame pulse it produces already has its full length.

Top module: `lcd_mono4_timing`

## Requirements
- R1: One Ts lasts 2*(s+1) cycles of `clk`, where s is `div_sel` (0..3). This is the memory clock divided by s+1.
- R2: A line lasts ((n+1)*8 + (m+1)*8 + 33) Ts, where n is `hdisp_n` and m is `hblank_m`. Within a line, positions are numbered 0 upward, one per Ts.
- R3: `lcd_line` is high during positions 0 to 8 of every line, which is exactly 9 Ts, and low for the rest of the line.
- R4: `lcd_shift` pulses once per Ts in positions 28 to 28+(n+1)*8-1, so its first rising edge comes 19 Ts after `lcd_line` falls. Each pulse is high in the first half of its Ts and low in the second half. The signal is low at all other times.
- R5: `px_ready` is high only in the last cycle before a shift Ts begins. A nibble with `px_valid` high in that cycle is shown on `lcd_data` for the whole following Ts. Without `px_valid`, that Ts shows 0. Outside shift positions `lcd_data` is 0.
- R6: `lcd_frame` rises at position 18 of the last line of a frame, which is 9 Ts after that line's pulse falls. It falls at position 18 of line 0, so it stays high for exactly one line period.
- R7: A frame has k+1 lines, where k is `vlines_k`. Lines are numbered 0 to k.
- R8: With `mod_line_mode` at 0, `lcd_acdrv` toggles at the start of each line 0. With `mod_line_mode` at 1, it toggles at the start of every line.
- R9: While `en` is 0, every output is 0 and `px_valid`/`px_data` have no effect. In the first cycle with `en` at 1 the block is at position 0 of a lead-in line numbered k, with `lcd_acdrv` at 0.
- R10: With k = 0, `lcd_frame` stays high for as long as the block is enabled, and `lcd_acdrv` toggles at every line start in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the memory-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; outputs low and counters restart while 0 |
| div_sel | input | 2 | Ts divider select s; Ts = memory clock / (s+1) |
| hdisp_n | input | 7 | Display width field n, (n+1)*8 Ts |
| hblank_m | input | 5 | Non-display width field m, (m+1)*8 Ts |
| vlines_k | input | VLINE_W | Lines per frame minus one |
| mod_line_mode | input | 1 | 0: AC toggle per frame, 1: per line |
| px_valid | input | 1 | Upstream nibble available |
| px_data | input | DATA_W | Upstream pixel nibble |
| px_ready | output | 1 | Nibble accepted this cycle when valid |
| lcd_line | output | 1 | Line pulse |
| lcd_frame | output | 1 | Frame pulse |
| lcd_shift | output | 1 | Shift clock |
| lcd_acdrv | output | 1 | AC-drive toggle |
| lcd_data | output | DATA_W | Panel data nibble |

## Verification
The bench sweeps every divider setting together with small display and blank widths, one-line and three-line frames, and both toggle modes. It also runs one configuration at the maximum width. In every cycle it compares all outputs with a model computed from the elapsed cycle count. The most delicate boundaries are the first and last shift positions and the line wrap. A design that is off by one Ts at either window edge would produce one shift pulse too many or one too few, and the mismatch would show at that edge. A divider that drifts, or a wrong line length, would shift every later pulse and break the comparison after the first line.

The frame pulse is checked across the frame wrap, including the case with one line per frame, where it must never drop. A design that tied the frame pulse to the line count alone would stay high too long or not long enough. Data underruns are scheduled every fifth Ts, so the zero-fill path is exercised as well. Finally, the bench drops `en` while `px_valid` is high and checks that all outputs go quiet.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int DIVSEL_W         = 2;
    localparam int HDISP_W          = 7;
    localparam int HBLANK_W         = 5;
    localparam int DIV_CNT_W        = DIVSEL_W + 1;

    localparam int LP_TS            = 9;
    localparam int SHIFT_LEAD_TS    = 19;
    localparam int FRAME_HOLD_TS    = 9;
    localparam int LINE_OVERHEAD_TS = 33;
    localparam int FIRST_SHIFT_TS   = LP_TS + SHIFT_LEAD_TS;
    localparam int FRAME_EDGE_TS    = LP_TS + FRAME_HOLD_TS;

    localparam int MAX_LINE_TS = (2 ** HDISP_W) * 8 + (2 ** HBLANK_W) * 8 + LINE_OVERHEAD_TS;
    localparam int HPOS_W      = $clog2(MAX_LINE_TS);

    typedef logic [HPOS_W-1:0] hpos_t;

    typedef enum logic {
        MOD_PER_FRAME = 1'b0,
        MOD_PER_LINE  = 1'b1
    } mod_mode_e;

    typedef struct packed {
        logic slot_end;
        logic first_half;
    } ts_phase_t;

    typedef struct packed {
        hpos_t pos;
        hpos_t pos_nxt;
        logic  wrap;
    } hstate_t;

    function automatic int disp_ts(logic [HDISP_W-1:0] n);
        return (int'(n) + 1) * 8;
    endfunction

    function automatic hpos_t line_len(logic [HDISP_W-1:0] n, logic [HBLANK_W-1:0] m);
        return hpos_t'(disp_ts(n) + (int'(m) + 1) * 8 + LINE_OVERHEAD_TS);
    endfunction

    function automatic logic in_shift(hpos_t p, logic [HDISP_W-1:0] n);
        int pi = int'(p);
        return (pi >= FIRST_SHIFT_TS) && (pi < FIRST_SHIFT_TS + disp_ts(n));
    endfunction

endpackage

// File: rtl/lcdt_ts_div.sv
module lcdt_ts_div
    import lcdt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [DIVSEL_W-1:0] div_sel,
    output ts_phase_t           ph
);

    logic [DIV_CNT_W-1:0] cnt_q;
    logic [DIV_CNT_W-1:0] cnt_last;
    logic [DIV_CNT_W-1:0] half_last;

    // A Ts spans 2*(s+1) cycles: last count 2s+1, first half ends at s.
    assign cnt_last  = {div_sel, 1'b1};
    assign half_last = {1'b0, div_sel};

    always_comb begin
        ph.slot_end   = (cnt_q == cnt_last);
        ph.first_half = (cnt_q <= half_last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (ph.slot_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_CNT_W'(1);
        end
    end

endmodule

// File: rtl/lcdt_hcount.sv
module lcdt_hcount
    import lcdt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                slot_end,
    input  logic [HDISP_W-1:0]  hdisp_n,
    input  logic [HBLANK_W-1:0] hblank_m,
    output hstate_t             hs
);

    hpos_t pos_q;
    hpos_t last_pos;

    assign last_pos = line_len(hdisp_n, hblank_m) - hpos_t'(1);

    always_comb begin
        logic at_end;
        at_end     = (pos_q == last_pos);
        hs.pos     = pos_q;
        hs.wrap    = at_end;
        hs.pos_nxt = at_end ? '0 : pos_q + hpos_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos_q <= '0;
        end else if (slot_end) begin
            pos_q <= hs.pos_nxt;
        end
    end

endmodule

// File: rtl/lcdt_vcount.sv
module lcdt_vcount #(
    parameter int VLINE_W = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               slot_end,
    input  logic               wrap,
    input  logic [VLINE_W-1:0] vlines_k,
    output logic [VLINE_W-1:0] line,
    output logic [VLINE_W-1:0] line_nxt
);

    logic [VLINE_W-1:0] line_q;

    assign line     = line_q;
    assign line_nxt = (line_q == vlines_k) ? '0 : line_q + VLINE_W'(1);

    // Idle value is the last line, so a run opens with a lead-in line.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            line_q <= vlines_k;
        end else if (slot_end && wrap) begin
            line_q <= line_nxt;
        end
    end

endmodule

// File: rtl/lcd_mono4_timing.sv
module lcd_mono4_timing
    import lcdt_pkg::*;
#(
    parameter int VLINE_W = 9,
    parameter int DATA_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [DIVSEL_W-1:0] div_sel,
    input  logic [HDISP_W-1:0]  hdisp_n,
    input  logic [HBLANK_W-1:0] hblank_m,
    input  logic [VLINE_W-1:0]  vlines_k,
    input  logic                mod_line_mode,
    input  logic                px_valid,
    input  logic [DATA_W-1:0]   px_data,
    output logic                px_ready,
    output logic                lcd_line,
    output logic                lcd_frame,
    output logic                lcd_shift,
    output logic                lcd_acdrv,
    output logic [DATA_W-1:0]   lcd_data
);

    ts_phase_t          ph;
    hstate_t            hs;
    logic [VLINE_W-1:0] line;
    logic [VLINE_W-1:0] line_nxt;
    logic               next_shifts;
    logic               mod_q;
    logic               toggle_now;
    logic [DATA_W-1:0]  nib_q;
    logic               fr_zone;

    lcdt_ts_div u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (en),
        .div_sel (div_sel),
        .ph      (ph)
    );

    lcdt_hcount u_hcnt (
        .clk      (clk),
        .rst      (rst),
        .run      (en),
        .slot_end (ph.slot_end),
        .hdisp_n  (hdisp_n),
        .hblank_m (hblank_m),
        .hs       (hs)
    );

    lcdt_vcount #(.VLINE_W(VLINE_W)) u_vcnt (
        .clk      (clk),
        .rst      (rst),
        .run      (en),
        .slot_end (ph.slot_end),
        .wrap     (hs.wrap),
        .vlines_k (vlines_k),
        .line     (line),
        .line_nxt (line_nxt)
    );

    assign next_shifts = in_shift(hs.pos_nxt, hdisp_n);
    assign px_ready    = en && ph.slot_end && next_shifts;

    // Nibble register loads at the edge where a shift Ts opens.
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            nib_q <= '0;
        end else if (ph.slot_end) begin
            nib_q <= (next_shifts && px_valid) ? px_data : '0;
        end
    end

    assign toggle_now = ph.slot_end && hs.wrap &&
                        ((mod_mode_e'(mod_line_mode) == MOD_PER_LINE) || (line_nxt == '0));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            mod_q <= 1'b0;
        end else if (toggle_now) begin
            mod_q <= ~mod_q;
        end
    end

    assign fr_zone = ((line == vlines_k) && (hs.pos >= hpos_t'(FRAME_EDGE_TS))) ||
                     ((line == '0)       && (hs.pos <  hpos_t'(FRAME_EDGE_TS)));

    assign lcd_line  = en && (hs.pos < hpos_t'(LP_TS));
    assign lcd_frame = en && fr_zone;
    assign lcd_shift = en && ph.first_half && in_shift(hs.pos, hdisp_n);
    assign lcd_acdrv = en && mod_q;
    assign lcd_data  = en ? nib_q : '0;

endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker
    import lcdt_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic [DIVSEL_W-1:0] div_sel,
    input logic [HDISP_W-1:0]  hdisp_n,
    input logic [HBLANK_W-1:0] hblank_m,
    input logic                px_ready,
    input logic                lcd_line,
    input logic                lcd_frame,
    input logic                lcd_shift,
    input logic                lcd_acdrv,
    input logic [DATA_W-1:0]   lcd_data
);

    logic [15:0] line_run;
    logic [15:0] frame_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_run  <= '0;
            frame_run <= '0;
        end else begin
            line_run  <= lcd_line  ? line_run  + 16'd1 : '0;
            frame_run <= lcd_frame ? frame_run + 16'd1 : '0;
        end
    end

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!lcd_line && !lcd_frame && !lcd_shift && !lcd_acdrv &&
                 lcd_data == '0 && !px_ready));

    p_line_width_r3: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && $fell(lcd_line)) |->
            (int'(line_run) == LP_TS * 2 * (int'(div_sel) + 1)));

    p_frame_span_r6: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && $fell(lcd_frame)) |->
            (int'(frame_run) == int'(line_len(hdisp_n, hblank_m)) * 2 * (int'(div_sel) + 1)));

    p_shift_clear_of_line_r4: assert property (@(posedge clk) disable iff (rst)
        lcd_shift |-> !lcd_line);

    p_ready_leads_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (en && px_ready) |=> (!en || lcd_shift));

    p_data_steady_r5: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && $past(lcd_shift) && lcd_shift) |-> $stable(lcd_data));

    p_mod_at_line_start_r8: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && (lcd_acdrv != $past(lcd_acdrv))) |-> $rose(lcd_line));

endmodule

bind lcd_mono4_timing lcdt_checker #(.DATA_W(DATA_W)) u_lcdt_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .div_sel   (div_sel),
    .hdisp_n   (hdisp_n),
    .hblank_m  (hblank_m),
    .px_ready  (px_ready),
    .lcd_line  (lcd_line),
    .lcd_frame (lcd_frame),
    .lcd_shift (lcd_shift),
    .lcd_acdrv (lcd_acdrv),
    .lcd_data  (lcd_data)
);

// File: tb/test_lcd_mono4_timing.sv
module test_lcd_mono4_timing;

    localparam int VW = 9;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          en;
    logic [1:0]    div_sel;
    logic [6:0]    hdisp_n;
    logic [4:0]    hblank_m;
    logic [VW-1:0] vlines_k;
    logic          mod_line_mode;
    logic          px_valid;
    logic [DW-1:0] px_data;
    logic          px_ready;
    logic          lcd_line;
    logic          lcd_frame;
    logic          lcd_shift;
    logic          lcd_acdrv;
    logic [DW-1:0] lcd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lcd_mono4_timing #(.VLINE_W(VW), .DATA_W(DW)) i_lcd_mono4_timing (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .div_sel       (div_sel),
        .hdisp_n       (hdisp_n),
        .hblank_m      (hblank_m),
        .vlines_k      (vlines_k),
        .mod_line_mode (mod_line_mode),
        .px_valid      (px_valid),
        .px_data       (px_data),
        .px_ready      (px_ready),
        .lcd_line      (lcd_line),
        .lcd_frame     (lcd_frame),
        .lcd_shift     (lcd_shift),
        .lcd_acdrv     (lcd_acdrv),
        .lcd_data      (lcd_data)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    function automatic bit src_valid(int t, int p);
        return ((t / p) % 5) != 2;
    endfunction

    function automatic int src_data(int t);
        return (t * 7 + 3) & 15;
    endfunction

    task automatic check_quiet(input string tag);
        check(lcd_line == 1'b0,  {tag, " line"},  int'(lcd_line),  0);
        check(lcd_frame == 1'b0, {tag, " frame"}, int'(lcd_frame), 0);
        check(lcd_shift == 1'b0, {tag, " shift"}, int'(lcd_shift), 0);
        check(lcd_acdrv == 1'b0, {tag, " acdrv"}, int'(lcd_acdrv), 0);
        check(lcd_data == '0,    {tag, " data"},  int'(lcd_data),  0);
        check(px_ready == 1'b0,  {tag, " ready"}, int'(px_ready),  0);
    endtask

    task automatic run_cfg(input int s, input int n, input int m, input int k, input int md);
        int d    = s + 1;
        int p    = 2 * d;
        int w    = (n + 1) * 8;
        int len  = w + (m + 1) * 8 + 33;
        int span = (1 + 2 * (k + 1)) * len * p + 3 * p;
        @(negedge clk);
        en            = 1'b0;
        div_sel       = 2'(s);
        hdisp_n       = 7'(n);
        hblank_m      = 5'(m);
        vlines_k      = VW'(k);
        mod_line_mode = 1'(md);
        px_valid      = 1'b0;
        px_data       = '0;
        @(negedge clk);
        for (int t = 0; t < span; t++) begin
            int slot  = t / p;
            int ph    = t % p;
            int li    = slot / len;
            int pos   = slot % len;
            int v     = (li == 0) ? k : (li - 1) % (k + 1);
            int npos  = (slot + 1) % len;
            int tog   = md ? li : ((li == 0) ? 0 : (li - 1) / (k + 1) + 1);
            bit win   = (pos >= 28) && (pos < 28 + w);
            bit nwin  = (npos >= 28) && (npos < 28 + w);
            bit e_ln  = pos < 9;
            bit e_sh  = win && (ph < d);
            bit e_fr  = ((v == k) && (pos >= 18)) || ((v == 0) && (pos < 18));
            bit e_md  = (tog % 2) == 1;
            bit e_rd  = (ph == p - 1) && nwin;
            int tc    = slot * p - 1;
            int e_dt  = (win && src_valid(tc, p)) ? src_data(tc) : 0;
            en       = 1'b1;
            px_valid = src_valid(t, p);
            px_data  = 4'(src_data(t));
            #1;
            check(lcd_line == e_ln,  "R1 R2 R3 lcd_line", int'(lcd_line), int'(e_ln));
            check(lcd_shift == e_sh, "R4 lcd_shift",      int'(lcd_shift), int'(e_sh));
            check(px_ready == e_rd,  "R5 px_ready",       int'(px_ready), int'(e_rd));
            check(int'(lcd_data) == e_dt, "R5 lcd_data",  int'(lcd_data), e_dt);
            if (k == 0) begin
                check(lcd_frame == e_fr, "R10 lcd_frame", int'(lcd_frame), int'(e_fr));
                check(lcd_acdrv == e_md, "R10 lcd_acdrv", int'(lcd_acdrv), int'(e_md));
            end else begin
                check(lcd_frame == e_fr, "R6 R7 lcd_frame", int'(lcd_frame), int'(e_fr));
                check(lcd_acdrv == e_md, "R8 lcd_acdrv",    int'(lcd_acdrv), int'(e_md));
            end
            @(negedge clk);
        end
        // R9: disabled block ignores the source and stays quiet
        en       = 1'b0;
        px_valid = 1'b1;
        px_data  = 4'hF;
        for (int i = 0; i < 3; i++) begin
            #1;
            check_quiet("R9 idle");
            @(negedge clk);
        end
    endtask

    initial begin
        rst           = 1'b1;
        en            = 1'b0;
        div_sel       = '0;
        hdisp_n       = '0;
        hblank_m      = '0;
        vlines_k      = '0;
        mod_line_mode = 1'b0;
        px_valid      = 1'b0;
        px_data       = '0;
        repeat (4) @(negedge clk);
        #1;
        check_quiet("R9 reset");
        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < 4; s++)
            for (int n = 0; n < 2; n++)
                for (int m = 0; m < 3; m += 2)
                    for (int k = 0; k < 3; k += 2)
                        for (int md = 0; md < 2; md++)
                            run_cfg(s, n, m, k, md);
        run_cfg(0, 127, 31, 0, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule